// File: doc/BRIEF.md
# Freezable Per-Channel DC Offset Remover

This block sits after the decimation stage of a multi-channel audio ADC and takes out the DC component of each channel. All channels share one input bus. A channel index travels with each sample. For each channel the block keeps a fixed-point estimate of the DC level and subtracts the whole-number part of that estimate from every valid sample. The result is saturated to the sample width.

Each channel has a hold bit in a small control register. When the bit is clear, the channel's estimate follows its input through a first-order leaky integrator. When the bit is set, the estimate stops moving, but the held value is still subtracted from every sample. A strap pin selects pin-strapped operation. In that mode every channel adapts and the register contents have no effect.

Top module: `dc_offset_remover`

## Requirements
- R1: Each channel, selected by `in_ch`, has its own estimate. A sample on one channel never changes the estimate or the output of another channel.
- R2: On a valid sample for an adapting channel, the estimate E, held with FRAC_W fractional bits (default 12), becomes E + ((x·2^FRAC_W − E) >>> SHIFT_K). The shift is arithmetic (floor), and SHIFT_K defaults to 12.
- R3: For each valid sample, the output is x − floor(E / 2^FRAC_W), where E is the estimate before that sample's update.
- R4: When a channel's effective hold bit is 1, valid samples leave its estimate unchanged, and the held estimate is still subtracted as in R3.
- R5: When `pin_mode` = 1, all channels adapt whatever the control register holds.
- R6: The control register resets to 0, so all channels adapt. A cycle with `cfg_we` = 1 loads `cfg_hold` (bit i is the hold bit for channel i). The new value applies from the next cycle's sample; a sample in the same cycle as the write still uses the old value.
- R7: The output is saturated to the signed DATA_W range (−2^23 … 2^23−1 by default) and never wraps.
- R8: `out_valid` is `in_valid` delayed by one clock. When `out_valid` is high, `out_ch` and `out_data` belong to that sample. A cycle with `in_valid` = 0 changes no estimate.
- R9: A synchronous active-high `rst` clears every estimate and the control register, and drives `out_valid` and `out_data` to 0.
- R10: Clearing a hold bit resumes adaptation from the held estimate. The estimate is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_mode | input | 1 | 1 = pin-strapped operation: all channels adapt and the register is ignored |
| cfg_we | input | 1 | Write strobe for the hold register |
| cfg_hold | input | NUM_CH | Hold bits to load, one per channel |
| in_valid | input | 1 | Input sample strobe |
| in_ch | input | CH_W | Channel index of the input sample |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_ch | output | CH_W | Channel index of the output sample |
| out_data | output | DATA_W | Signed, offset-corrected, saturated sample |

## Verification
The assertions assume that `in_valid` stays low while `rst` is high and that `in_ch` always names an existing channel. The stimulus keeps to both: it holds the strobe low through every reset and draws channel numbers only from 0 to NUM_CH−1. The no-wrap check assumes that the estimate always lies inside the sample range. The bench keeps this true because it drives only in-range samples, from which the integrator's estimate cannot escape. Long full-scale runs push the estimate close to either rail, so that both saturation directions are reached legitimately.

// File: rtl/dcrm_pkg.sv
package dcrm_pkg;
  typedef enum logic {
    MODE_REGISTER = 1'b0,
    MODE_STRAPPED = 1'b1
  } op_mode_e;
endpackage

// File: rtl/dcrm_ctrl.sv
module dcrm_ctrl #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_mode,
  input  logic              cfg_we,
  input  logic [NUM_CH-1:0] cfg_hold,
  output logic [NUM_CH-1:0] freeze_mask
);
  import dcrm_pkg::*;

  logic [NUM_CH-1:0] hold_q;
  op_mode_e          mode;

  always_ff @(posedge clk) begin
    if (rst)         hold_q <= '0;
    else if (cfg_we) hold_q <= cfg_hold;
  end

  assign mode = op_mode_e'(pin_mode);

  always_comb begin
    if (mode == MODE_STRAPPED) freeze_mask = '0;
    else                       freeze_mask = hold_q;
  end

  // R6: a write lands in the register at the next edge
  p_cfg_load_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !pin_mode) |=> (freeze_mask == $past(cfg_hold)) || pin_mode);

endmodule

// File: rtl/dcrm_est_bank.sv
module dcrm_est_bank #(
  parameter int NUM_CH = 4,
  parameter int EST_W  = 36,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [CH_W-1:0]              wr_addr,
  input  logic [EST_W-1:0]             wr_data,
  input  logic [CH_W-1:0]              rd_addr,
  output logic [EST_W-1:0]             rd_data,
  output logic [NUM_CH-1:0][EST_W-1:0] all_q
);
  logic [NUM_CH-1:0][EST_W-1:0] q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)
        q[i] <= '0;
      else if (wr_en && (wr_addr == CH_W'(i)))
        q[i] <= wr_data;
    end
  end

  assign rd_data = q[rd_addr];
  assign all_q   = q;

endmodule

// File: rtl/dcrm_track.sv
module dcrm_track #(
  parameter int DATA_W  = 24,
  parameter int FRAC_W  = 12,
  parameter int SHIFT_K = 12,
  localparam int EST_W  = DATA_W + FRAC_W,
  localparam int WIDE_W = EST_W + 1
) (
  input  logic [DATA_W-1:0] x,
  input  logic [EST_W-1:0]  est_cur,
  output logic [EST_W-1:0]  est_next,
  output logic [DATA_W-1:0] y
);
  localparam logic [DATA_W-1:0] SAT_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] SAT_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [WIDE_W-1:0] x_scaled;
  logic signed [WIDE_W-1:0] est_ext;
  logic signed [WIDE_W-1:0] diff;
  logic signed [WIDE_W-1:0] step;
  logic signed [WIDE_W-1:0] sum;
  logic signed [DATA_W:0]   sub;
  logic [DATA_W-1:0]        est_int;

  // leaky integrator update
  always_comb begin
    x_scaled = $signed({x[DATA_W-1], x, {FRAC_W{1'b0}}});
    est_ext  = $signed({est_cur[EST_W-1], est_cur});
    diff     = x_scaled - est_ext;
    step     = diff >>> SHIFT_K;
    sum      = est_ext + step;
    est_next = sum[EST_W-1:0];
  end

  // subtract the integer part of the estimate, then saturate
  always_comb begin
    est_int = est_cur[EST_W-1:FRAC_W];
    sub     = $signed({x[DATA_W-1], x}) - $signed({est_int[DATA_W-1], est_int});
    if (sub[DATA_W] != sub[DATA_W-1])
      y = sub[DATA_W] ? SAT_MIN : SAT_MAX;
    else
      y = sub[DATA_W-1:0];
  end

endmodule

// File: rtl/dc_offset_remover.sv
module dc_offset_remover #(
  parameter int NUM_CH  = 4,
  parameter int DATA_W  = 24,
  parameter int FRAC_W  = 12,
  parameter int SHIFT_K = 12,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int EST_W  = DATA_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_mode,
  input  logic              cfg_we,
  input  logic [NUM_CH-1:0] cfg_hold,
  input  logic              in_valid,
  input  logic [CH_W-1:0]   in_ch,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_ch,
  output logic [DATA_W-1:0] out_data
);
  logic [NUM_CH-1:0]             freeze_mask;
  logic                          frz;
  logic                          est_we;
  logic [EST_W-1:0]              est_rd;
  logic [EST_W-1:0]              est_nx;
  logic [DATA_W-1:0]             y;
  logic [NUM_CH-1:0][EST_W-1:0]  est_all;

  dcrm_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rst(rst), .pin_mode(pin_mode), .cfg_we(cfg_we),
    .cfg_hold(cfg_hold), .freeze_mask(freeze_mask)
  );

  assign frz    = freeze_mask[in_ch];
  assign est_we = in_valid && !frz;

  dcrm_est_bank #(.NUM_CH(NUM_CH), .EST_W(EST_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(est_we), .wr_addr(in_ch), .wr_data(est_nx),
    .rd_addr(in_ch), .rd_data(est_rd), .all_q(est_all)
  );

  dcrm_track #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .SHIFT_K(SHIFT_K)) u_track (
    .x(in_data), .est_cur(est_rd), .est_next(est_nx), .y(y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_ch   <= in_ch;
        out_data <= y;
      end
    end
  end

  // R8: one-stage strobe delay
  p_valid_delay_r8: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_valid) |=> out_valid);
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!rst && !in_valid) |=> !out_valid);
  // R8: idle cycles change no estimate
  p_idle_est_r8: assert property (@(posedge clk) disable iff (rst)
    (!rst && !in_valid) |=> (est_all == $past(est_all)));
  // R4: a frozen channel keeps its estimate
  p_hold_est_r4: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_valid && frz) |=> (est_all[$past(in_ch)] == $past(est_all[in_ch])));
  // R7: non-negative input minus non-positive estimate never wraps low
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_valid && !in_data[DATA_W-1] && est_rd[EST_W-1])
      |=> ($signed(out_data) >= $signed($past(in_data))));

endmodule

// File: tb/dc_offset_remover_test.sv
module dc_offset_remover_test;
  localparam int NCH = 4;
  localparam int DW  = 24;
  localparam int FW  = 12;
  localparam int KS  = 12;
  localparam longint SMAX = (64'sd1 <<< (DW-1)) - 1;
  localparam longint SMIN = -(64'sd1 <<< (DW-1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin_mode = 1'b0;
  logic cfg_we = 1'b0;
  logic [NCH-1:0] cfg_hold = '0;
  logic in_valid = 1'b0;
  logic [1:0] in_ch = '0;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic [1:0] out_ch;
  logic [DW-1:0] out_data;

  always #10 clk = ~clk;

  dc_offset_remover uut (
    .clk(clk), .rst(rst), .pin_mode(pin_mode), .cfg_we(cfg_we), .cfg_hold(cfg_hold),
    .in_valid(in_valid), .in_ch(in_ch), .in_data(in_data),
    .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data)
  );

  int checks = 0;
  int failures = 0;
  longint est_m [NCH];
  logic [NCH-1:0] hreg_m;
  logic exp_v;
  int exp_ch;
  longint exp_y;

  function automatic longint sat(input longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    foreach (est_m[i]) est_m[i] = 0;
    hreg_m = '0;
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      failures++;
      $display("FAIL R9 reset: out_valid=%0b out_data=%0d expected 0/0", out_valid, out_data);
    end
  endtask

  task automatic step(input logic v, input int ch, input longint x,
                      input logic we, input logic [NCH-1:0] wd, input string tag);
    logic hold;
    @(negedge clk);
    in_valid = v; in_ch = 2'(ch); in_data = DW'(x); cfg_we = we; cfg_hold = wd;
    exp_v = v;
    if (v) begin
      hold   = !pin_mode && hreg_m[ch];
      exp_ch = ch;
      exp_y  = sat(x - (est_m[ch] >>> FW));
      if (!hold) est_m[ch] = est_m[ch] + (((x <<< FW) - est_m[ch]) >>> KS);
    end
    if (we) hreg_m = wd;
    @(posedge clk);
    #1;
    checks++;
    if (out_valid !== exp_v) begin
      failures++;
      $display("FAIL %s out_valid=%0b expected %0b", tag, out_valid, exp_v);
    end else if (exp_v && (int'(out_ch) != exp_ch || longint'($signed(out_data)) != exp_y)) begin
      failures++;
      $display("FAIL %s ch=%0d data=%0d expected ch=%0d data=%0d", tag,
               out_ch, $signed(out_data), exp_ch, exp_y);
    end
  endtask

  task automatic expect_data(input longint e, input string tag);
    checks++;
    if (longint'($signed(out_data)) != e) begin
      failures++;
      $display("FAIL %s data=%0d expected %0d", tag, $signed(out_data), e);
    end
  endtask

  task automatic run_all();
    do_reset();
    // R3: first sample sees a zero estimate
    step(1, 0, 1234, 0, '0, "R3");
    expect_data(1234, "R3");
    // R1 R2 R3: four channels with distinct DC levels, interleaved
    for (int n = 0; n < 3000; n++) begin
      step(1, 0, 1000 + (n % 7), 0, '0, "R2");
      step(1, 1, -50000, 0, '0, "R1");
      step(1, 2, (n % 2) ? 300000 : -300000, 0, '0, "R3");
      if (n % 5 == 0) step(0, 3, 77, 0, '0, "R8");
      else            step(1, 3, 0, 0, '0, "R1");
    end
    // R6: write in same cycle as a ch1 sample; that sample still adapts
    step(1, 1, 40000, 1, 4'b0010, "R6");
    // R4: ch1 frozen; constant input keeps producing the same output
    for (int n = 0; n < 200; n++) begin
      step(1, 1, 40000, 0, '0, "R4");
      step(1, 0, 1000, 0, '0, "R4");
    end
    // R5: strapped mode ignores the register
    pin_mode = 1'b1;
    for (int n = 0; n < 200; n++) step(1, 1, 40000, 0, '0, "R5");
    pin_mode = 1'b0;
    step(1, 1, 40000, 0, '0, "R4");
    // R10: release the hold and resume from the held estimate
    step(0, 0, 0, 1, 4'b0000, "R10");
    for (int n = 0; n < 300; n++) step(1, 1, 40000, 0, '0, "R10");
    // R7: drive ch2 near the top rail, then hit it with full negative
    for (int n = 0; n < 8192; n++) step(1, 2, SMAX, 0, '0, "R7");
    step(1, 2, SMIN, 0, '0, "R7");
    expect_data(SMIN, "R7");
    for (int n = 0; n < 8192; n++) step(1, 3, SMIN, 0, '0, "R7");
    step(1, 3, SMAX, 0, '0, "R7");
    expect_data(SMAX, "R7");
    // R9: reset clears estimates and the hold register
    step(0, 0, 0, 1, 4'b1111, "R9");
    do_reset();
    step(1, 2, 500, 0, '0, "R9");
    expect_data(500, "R9");
    step(1, 3, -700, 0, '0, "R9");
    step(1, 3, -700, 0, '0, "R9");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule